// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is a byte-addressed arithmetic unit. It performs an unsigned 8x8 multiply or an unsigned 16/8 divide, one step per clock. Software first writes the operand registers. A write to the multiplier register starts a multiply, and a write to the divisor register starts a divide. Results come back as two 16-bit values, each read as a low byte and a high byte.

The first result is the quotient register. At the start of a multiply it holds the operand pair; at the end of a divide it holds the quotient. The second result is the product/remainder register. Both registers change on every step, so a read taken before the operation completes returns the partial state at that moment. A multiply takes exactly eight steps and a divide exactly sixteen. While either one runs, `busy` is high and any further start write is refused.

Top module: `seq_muldiv`

## Requirements
- R1: The write addresses are: 0 for the multiplicand, 1 for the multiplier (this write starts a multiply), 2 for the dividend low byte, 3 for the dividend high byte, and 4 for the divisor (this write starts a divide). The read addresses are: 0 for quotient bits 7:0, 1 for quotient bits 15:8, 2 for product/remainder bits 7:0, and 3 for product/remainder bits 15:8. Reads are combinational.
- R2: Every write to the multiplier address sets the product/remainder register to zero on that edge, including a write made while the unit is busy.
- R3: When a multiply starts, the quotient register is loaded with {multiplier, multiplicand}. When the multiply completes, the product/remainder register holds multiplicand*multiplier and the quotient register holds the multiplier.
- R4: `busy` rises on the edge of the multiplier write and stays high for exactly 8 clock cycles.
- R5: `busy` rises on the edge of the divisor write and stays high for exactly 16 clock cycles. When the divide completes, the quotient register holds dividend/divisor and the product/remainder register holds dividend%divisor.
- R6: Every write to the divisor address loads the product/remainder register with the current 16-bit dividend, including a write made while the unit is busy.
- R7: A start write made while `busy` is high does not begin a new operation. The operation already running keeps its length and its quotient result.
- R8: A divide by zero finishes with a quotient of 0xFFFF and a remainder equal to the dividend.
- R9: After synchronous reset, `busy` is low and all four read addresses return 0.
- R10: Results can be read mid-operation. After one multiply step with multiplicand 3 and multiplier 5, the quotient register reads 0x0281 and the product/remainder register reads 0x0005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Read data byte |
| busy | output | 1 | High while an operation is running |

## Verification
Multiplies are run with operand values that exercise the arithmetic in different ways: zeros, the all-ones extreme, single-bit operands, and mixed bit patterns. Between them these cover cases where no partial product is added, cases where every partial product is added, and the full-carry case.

Divides are run with different quotient and remainder outcomes: an exact quotient, a quotient with a remainder, a dividend smaller than the divisor (quotient 0), a divisor of one, and a divisor of zero. These show whether the compare-and-subtract restores the partial remainder correctly, and whether the all-ones quotient appears for a zero divisor.

Directed tests then cover the reset state, a read taken after a single step, and a start write issued during an operation. The last test separates the result-register side effect of such a write from the restart that must not happen.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} op_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] WA_MCAND  = 3'd0;
    localparam logic [ADDR_W-1:0] WA_MPLIER = 3'd1;
    localparam logic [ADDR_W-1:0] WA_DVD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] WA_DVD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] WA_DIVSR  = 3'd4;

    localparam logic [1:0] RA_QUOT_LO = 2'd0;
    localparam logic [1:0] RA_QUOT_HI = 2'd1;
    localparam logic [1:0] RA_PROD_LO = 2'd2;
    localparam logic [1:0] RA_PROD_HI = 2'd3;
endpackage

// File: rtl/mdu_operands.sv
module mdu_operands
    import mdu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [OPW-1:0]    wr_data,
    output logic [OPW-1:0]    mcand_o,
    output logic [2*OPW-1:0]  dividend_o,
    output logic              start_mul_o,
    output logic              start_div_o
);
    localparam int PW = 2 * OPW;

    logic [OPW-1:0] mcand_q;
    logic [PW-1:0]  dvd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            dvd_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WA_MCAND:  mcand_q            <= wr_data;
                WA_DVD_LO: dvd_q[OPW-1:0]     <= wr_data;
                WA_DVD_HI: dvd_q[PW-1:OPW]    <= wr_data;
                default: ;
            endcase
        end
    end

    assign mcand_o     = mcand_q;
    assign dividend_o  = dvd_q;
    assign start_mul_o = wr_en && (wr_addr == WA_MPLIER);
    assign start_div_o = wr_en && (wr_addr == WA_DIVSR);

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        !(start_mul_o && start_div_o)); // R1
endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
    import mdu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_mul,
    input  logic             start_div,
    input  logic [OPW-1:0]   mcand_i,
    input  logic [OPW-1:0]   load_i,
    input  logic [2*OPW-1:0] dividend_i,
    output logic [2*OPW-1:0] quot_o,
    output logic [2*OPW-1:0] prod_o,
    output logic             busy_o
);
    localparam int PW = 2 * OPW;
    localparam int SW = 3 * OPW;
    localparam int CW = $clog2(PW + 1);
    localparam logic [CW-1:0] MUL_STEPS = CW'(OPW);
    localparam logic [CW-1:0] DIV_STEPS = CW'(PW);

    logic [PW-1:0] quot_q, prod_q, quot_s, prod_s;
    logic [SW-1:0] shift_q, shift_s, shift_dn;
    logic [CW-1:0] cnt_q;
    op_e           mode_q;

    assign busy_o = (cnt_q != '0);

    always_comb begin
        shift_dn = shift_q >> 1;
        if (mode_q == OP_MUL) begin
            prod_s  = quot_q[0] ? prod_q + shift_q[PW-1:0] : prod_q;
            quot_s  = quot_q >> 1;
            shift_s = shift_q << 1;
        end else begin
            shift_s = shift_dn;
            if ({{OPW{1'b0}}, prod_q} >= shift_dn) begin
                prod_s = prod_q - shift_dn[PW-1:0];
                quot_s = {quot_q[PW-2:0], 1'b1};
            end else begin
                prod_s = prod_q;
                quot_s = {quot_q[PW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quot_q  <= '0;
            prod_q  <= '0;
            shift_q <= '0;
            cnt_q   <= '0;
            mode_q  <= OP_MUL;
        end else begin
            if (busy_o) begin
                quot_q  <= quot_s;
                prod_q  <= prod_s;
                shift_q <= shift_s;
                cnt_q   <= cnt_q - 1'b1;
            end
            if (start_mul) begin
                prod_q <= '0;
                if (!busy_o) begin
                    quot_q  <= {load_i, mcand_i};
                    shift_q <= {{(SW-OPW){1'b0}}, load_i};
                    cnt_q   <= MUL_STEPS;
                    mode_q  <= OP_MUL;
                end
            end
            if (start_div) begin
                prod_q <= dividend_i;
                if (!busy_o) begin
                    shift_q <= {load_i, {PW{1'b0}}};
                    cnt_q   <= DIV_STEPS;
                    mode_q  <= OP_DIV;
                end
            end
        end
    end

    assign quot_o = quot_q;
    assign prod_o = prod_q;

    AST_MUL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start_mul |=> prod_o == '0); // R2
    AST_MUL_LOAD: assert property (@(posedge clk) disable iff (rst)
        start_mul && !busy_o |=> quot_o == {$past(load_i), $past(mcand_i)} && cnt_q == MUL_STEPS); // R3
    AST_DIV_LOAD: assert property (@(posedge clk) disable iff (rst)
        start_div |=> prod_o == $past(dividend_i)); // R6
    AST_DIV_LEN: assert property (@(posedge clk) disable iff (rst)
        start_div && !busy_o |=> cnt_q == DIV_STEPS && mode_q == OP_DIV); // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy_o && (start_mul || start_div) |=> cnt_q == CW'($past(cnt_q) - 1'b1)); // R7
    AST_ZERO_DIVSR: assert property (@(posedge clk) disable iff (rst)
        busy_o && mode_q == OP_DIV && shift_q == '0 |=> quot_o[0]); // R8
    AST_MUL_TAIL: assert property (@(posedge clk) disable iff (rst)
        busy_o && mode_q == OP_MUL |=> quot_o[PW-1] == 1'b0); // R3
endmodule

// File: rtl/mdu_readmux.sv
module mdu_readmux
    import mdu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [1:0]       rd_addr,
    input  logic [2*OPW-1:0] quot_i,
    input  logic [2*OPW-1:0] prod_i,
    output logic [OPW-1:0]   rd_data
);
    localparam int PW = 2 * OPW;

    always_comb begin
        case (rd_addr)
            RA_QUOT_LO: rd_data = quot_i[OPW-1:0];
            RA_QUOT_HI: rd_data = quot_i[PW-1:OPW];
            RA_PROD_LO: rd_data = prod_i[OPW-1:0];
            default:    rd_data = prod_i[PW-1:OPW];
        endcase
    end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
    import mdu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [OPW-1:0]    wr_data,
    input  logic [1:0]        rd_addr,
    output logic [OPW-1:0]    rd_data,
    output logic              busy
);
    localparam int PW = 2 * OPW;

    logic [OPW-1:0] mcand;
    logic [PW-1:0]  dividend, quot, prod;
    logic           start_mul, start_div;

    mdu_operands #(.OPW(OPW)) u_opnd (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mcand_o(mcand), .dividend_o(dividend),
        .start_mul_o(start_mul), .start_div_o(start_div)
    );

    mdu_engine #(.OPW(OPW)) u_eng (
        .clk(clk), .rst(rst), .start_mul(start_mul), .start_div(start_div),
        .mcand_i(mcand), .load_i(wr_data), .dividend_i(dividend),
        .quot_o(quot), .prod_o(prod), .busy_o(busy)
    );

    mdu_readmux #(.OPW(OPW)) u_rd (
        .rd_addr(rd_addr), .quot_i(quot), .prod_i(prod), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_seq_muldiv.sv
module sim_seq_muldiv;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // {is_div, a[15:0] (multiplicand uses low byte), b[7:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 16'd0,      8'd0},
        {1'b0, 16'd255,    8'd255},
        {1'b0, 16'd3,      8'd5},
        {1'b0, 16'd128,    8'd2},
        {1'b0, 16'd1,      8'd255},
        {1'b1, 16'd100,    8'd7},
        {1'b1, 16'hFFFF,   8'd1},
        {1'b1, 16'hFFFF,   8'd255},
        {1'b1, 16'd5,      8'd10},
        {1'b1, 16'd1234,   8'd0},
        {1'b1, 16'd0,      8'd3}
    };

    logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, busy;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic [1:0] rd_addr = '0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_muldiv u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd16(input logic hi_sel_prod, output logic [15:0] v);
        rd_addr = {hi_sel_prod, 1'b0}; #1; v[7:0] = rd_data;
        rd_addr = {hi_sel_prod, 1'b1}; #1; v[15:8] = rd_data;
    endtask

    initial begin
        logic [15:0] q, p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 busy", {15'd0, busy}, 16'd0);
        rd16(1'b0, q); rd16(1'b1, p);
        chk("R9 quot", q, 16'd0);
        chk("R9 prod", p, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic        is_div;
            logic [15:0] a, eq, ep;
            logic [7:0]  b;
            int          n;
            {is_div, a, b} = VEC[i];
            if (is_div) begin
                wr(3'd2, a[7:0]); wr(3'd3, a[15:8]);   // R1 dividend bytes
                wr(3'd4, b);
                n  = 16;
                eq = (b == 0) ? 16'hFFFF : a / {8'd0, b};   // R8
                ep = (b == 0) ? a : a % {8'd0, b};
            end else begin
                wr(3'd0, a[7:0]);
                wr(3'd1, b);
                n  = 8;
                eq = {8'd0, b};
                ep = a[7:0] * b;
            end
            repeat (n - 1) @(negedge clk);
            chk(is_div ? "R5 busy held" : "R4 busy held", {15'd0, busy}, 16'd1);
            @(negedge clk);
            chk(is_div ? "R5 busy fell" : "R4 busy fell", {15'd0, busy}, 16'd0);
            rd16(1'b0, q); rd16(1'b1, p);
            chk(is_div ? "R5 quotient" : "R3 quot reg", q, eq);
            chk(is_div ? "R5 remainder" : "R3 product", p, ep);
        end

        // R10 partial state after one multiply step; R3 start load
        wr(3'd0, 8'd3);
        wr(3'd1, 8'd5);
        rd16(1'b0, q);
        chk("R3 start load", q, 16'h0503);
        @(negedge clk);
        rd16(1'b0, q); rd16(1'b1, p);
        chk("R10 partial quot", q, 16'h0281);
        chk("R10 partial prod", p, 16'h0005);
        repeat (7) @(negedge clk);

        // R6 / R7: divisor write during a multiply
        wr(3'd2, 8'h34); wr(3'd3, 8'h12);
        wr(3'd0, 8'd9);
        wr(3'd1, 8'd6);          // start, 0 steps done
        wr(3'd4, 8'd2);          // refused start at step 2
        rd16(1'b1, p);
        chk("R6 dividend load when busy", p, 16'h1234);
        repeat (5) @(negedge clk);
        chk("R7 still busy", {15'd0, busy}, 16'd1);
        @(negedge clk);
        chk("R7 no restart", {15'd0, busy}, 16'd0);
        rd16(1'b0, q);
        chk("R7 quot kept", q, 16'd6);

        // R2: multiplier write while busy clears product
        wr(3'd2, 8'd200); wr(3'd3, 8'd0);
        wr(3'd4, 8'd3);          // divide starts, prod=200
        wr(3'd1, 8'd7);          // refused, prod cleared
        rd16(1'b1, p);
        chk("R2 clear when busy", p, 16'd0);
        repeat (14) @(negedge clk);
        chk("R7 div not restarted", {15'd0, busy}, 16'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule